// File: doc/BRIEF.md
# Line brown-out qualification sequencer

This block decides whether a low-line indication from an external analog comparator is a real brown-out or a short mains dropout. The comparator output enters through a clock-domain synchronizer. When it first reports a low line, the sequencer enables the pin clamp and runs two timed phases back to back. The first is a blanking phase, during which the indication is ignored. The second is a detection window, during which any low-line sample confirms the fault. If no such sample arrives during the window, the block goes back to normal operation. Both phases are counted in pulses of a slow tick input, normally one per millisecond.

When a fault is confirmed, the block raises the brown-out flag, drops the clamp enable and turns on the hysteresis current sink enable. The flag clears after two consecutive low-line-free samples. During reset, while the supply is not ready, or while shutdown is requested, the block holds the flag high. The sink enable stays off until the supply has been reported ready at least once.

Top module: `lbo_qualifier`

## Requirements
- R1: While `rst_n` is low the flag is high and the clamp enable is low. While `supply_ok` is low or `shutdown_req` is high, the flag is high and the clamp enable is low from the next clock edge on.
- R2: `sink_en` stays low until `supply_ok` has been sampled high at least once. After that it is high whenever the block is held off (R1 conditions) or a fault is being indicated.
- R3: `line_low_raw` (1 = line below threshold) passes through `SYNC_STAGES` flops, 2 by default. With the sequencer idle, take the first edge that samples the input high as edge 0. `clamp_en` is then high after edge 2 and still low after edge 1.
- R4: For `BLANK_TICKS` tick pulses after the clamp asserts, the flag does not rise, whatever `line_low_raw` does. Without tick pulses the blanking phase never ends.
- R5: During the next `WINDOW_TICKS` tick pulses, a single synchronized low-line sample raises the flag.
- R6: If the window passes with no low-line sample, the flag stays low and the clamp enable returns low.
- R7: While the flag is high, `clamp_en` is low and, once R2 allows, `sink_en` is high.
- R8: The flag clears only after the synchronized input has been low on two consecutive clock edges. A single low sample between high samples leaves the flag high.
- R9: On leaving the held-off condition, the block starts with the flag high. It enters normal operation only through the R8 rule.
- R10: Both phase counters restart from zero on every new sequence. A sequence cut short by a hold-off does not shorten the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle timing pulse that advances the phase counters |
| line_low_raw | input | 1 | Asynchronous comparator output, 1 = line below threshold |
| supply_ok | input | 1 | Supply ready, synchronous to clk |
| shutdown_req | input | 1 | Shutdown request, synchronous to clk |
| bo_fault | output | 1 | Brown-out flag |
| clamp_en | output | 1 | Enable for the pin clamp source |
| sink_en | output | 1 | Enable for the hysteresis current sink |

## Verification
The bench probes the edge between blanking and window with dropouts one cycle apart. A dropout that ends just inside blanking must pass. One that lasts one more cycle must trip. A design whose counter is off by one, or that starts the window one tick early, would swap these two results. Second pulses placed inside blanking, inside the window and just after the window show whether the window opens and closes on the right ticks. Other tests cover a single clean sample while the fault is held, a hold-off in the middle of blanking followed by a new sequence, and startup with shutdown held. These catch a one-sample release, counters that are not cleared, and a sink enabled before the supply is ready.

// File: rtl/lbo_pkg.sv
package lbo_pkg;
   typedef enum logic [2:0] {
      ST_OFF    = 3'd0,
      ST_FAULT  = 3'd1,
      ST_RUN    = 3'd2,
      ST_BLANK  = 3'd3,
      ST_WINDOW = 3'd4
   } lbo_state_e;
endpackage

// File: rtl/lbo_sync.sv
module lbo_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[0] <= 1'b0;
            else        sh[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[i] <= 1'b0;
            else        sh[i] <= sh[i-1];
         end
      end
   end

   assign q = sh[STAGES-1];

   // R3
   sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q == $past(sh[STAGES-2]));
endmodule

// File: rtl/lbo_tick_timer.sv
module lbo_tick_timer #(
   parameter int LEN = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   output logic done
);
   localparam int CW = $clog2(LEN + 1);

   logic [CW-1:0] cnt;

   assign done = run && tick && (cnt == CW'(LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (!run)     cnt <= '0;
      else if (done)     cnt <= '0;
      else if (tick)     cnt <= cnt + 1'b1;
   end

   // R10
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(LEN));
   // R10
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));
endmodule

// File: rtl/lbo_seq_fsm.sv
module lbo_seq_fsm
   import lbo_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic line_low,
   input  logic supply_ok,
   input  logic shutdown_req,
   input  logic blank_done,
   input  logic win_done,
   output logic blank_run,
   output logic win_run,
   output logic bo_fault,
   output logic clamp_en,
   output logic sink_en
);
   lbo_state_e state, nxt;
   logic       armed;
   logic       low_seen;
   logic       hold_off;

   assign hold_off = !supply_ok || shutdown_req;

   always_comb begin
      nxt = state;
      if (hold_off) begin
         nxt = ST_OFF;
      end else begin
         case (state)
            ST_OFF:    nxt = ST_FAULT;
            ST_FAULT:  if (!line_low && low_seen) nxt = ST_RUN;
            ST_RUN:    if (line_low) nxt = ST_BLANK;
            ST_BLANK:  if (blank_done) nxt = ST_WINDOW;
            ST_WINDOW: begin
               if (line_low)      nxt = ST_FAULT;
               else if (win_done) nxt = ST_RUN;
            end
            default:   nxt = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_OFF;
         armed    <= 1'b0;
         low_seen <= 1'b0;
      end else begin
         state    <= nxt;
         armed    <= armed | supply_ok;
         low_seen <= (state == ST_FAULT) && !line_low;
      end
   end

   assign blank_run = (state == ST_BLANK);
   assign win_run   = (state == ST_WINDOW);
   assign bo_fault  = (state == ST_OFF) || (state == ST_FAULT);
   assign clamp_en  = (state == ST_BLANK) || (state == ST_WINDOW);
   assign sink_en   = (state == ST_FAULT) || ((state == ST_OFF) && armed);

   // R1
   hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_off |=> (bo_fault && !clamp_en));
   // R2
   sink_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !sink_en);
   // R4
   blank_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BLANK) |=> !bo_fault || $past(hold_off));
   // R5
   window_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WINDOW && line_low) |=> bo_fault);
   // R6
   quiet_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WINDOW && win_done && !line_low && !hold_off) |=> (state == ST_RUN));
   // R8
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FAULT && line_low && !hold_off) |=> (state == ST_FAULT));
   // R9
   off_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OFF) |=> bo_fault);
endmodule

// File: rtl/lbo_qualifier.sv
module lbo_qualifier #(
   parameter int SYNC_STAGES  = 2,
   parameter int BLANK_TICKS  = 50,
   parameter int WINDOW_TICKS = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_ms,
   input  logic line_low_raw,
   input  logic supply_ok,
   input  logic shutdown_req,
   output logic bo_fault,
   output logic clamp_en,
   output logic sink_en
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (BLANK_TICKS < 1) begin : g_bad_blank
      $error("BLANK_TICKS must be at least 1");
   end
   if (WINDOW_TICKS < 1) begin : g_bad_window
      $error("WINDOW_TICKS must be at least 1");
   end

   logic line_low_s;
   logic blank_run, blank_done;
   logic win_run, win_done;

   lbo_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (line_low_raw),
      .q     (line_low_s)
   );

   lbo_tick_timer #(.LEN(BLANK_TICKS)) u_blank_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (blank_run),
      .tick  (tick_ms),
      .done  (blank_done)
   );

   lbo_tick_timer #(.LEN(WINDOW_TICKS)) u_win_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (win_run),
      .tick  (tick_ms),
      .done  (win_done)
   );

   lbo_seq_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .line_low     (line_low_s),
      .supply_ok    (supply_ok),
      .shutdown_req (shutdown_req),
      .blank_done   (blank_done),
      .win_done     (win_done),
      .blank_run    (blank_run),
      .win_run      (win_run),
      .bo_fault     (bo_fault),
      .clamp_en     (clamp_en),
      .sink_en      (sink_en)
   );

   // R7
   fault_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bo_fault |-> !clamp_en);
endmodule

// File: tb/lbo_qualifier_bench.sv
module lbo_qualifier_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_ms = 1'b0;
   logic line_low_raw = 1'b0;
   logic supply_ok = 1'b0;
   logic shutdown_req = 1'b1;
   logic bo_fault, clamp_en, sink_en;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   bit seen_bo, seen_cl;

   always #10 clk = ~clk;

   lbo_qualifier #(.SYNC_STAGES(2), .BLANK_TICKS(4), .WINDOW_TICKS(3)) u_lbo_qualifier (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_ms      (tick_ms),
      .line_low_raw (line_low_raw),
      .supply_ok    (supply_ok),
      .shutdown_req (shutdown_req),
      .bo_fault     (bo_fault),
      .clamp_en     (clamp_en),
      .sink_en      (sink_en)
   );

   // dropout patterns: first pulse, gap, second pulse, fault expected
   localparam int NV = 8;
   localparam int P_LEN[NV] = '{1, 5, 6, 9, 1, 1, 2, 1};
   localparam int P_GAP[NV] = '{0, 0, 0, 0, 5, 2, 4, 7};
   localparam int P_SEC[NV] = '{0, 0, 0, 0, 1, 1, 1, 1};
   localparam bit P_EXP[NV] = '{0, 0, 1, 1, 1, 0, 1, 0};

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
      seen_bo |= bo_fault;
      seen_cl |= clamp_en;
   endtask

   task automatic run_pat(input int l, input int g, input int s, input bit exp);
      seen_bo = 1'b0;
      seen_cl = 1'b0;
      line_low_raw = 1'b1;
      repeat (l) step();
      line_low_raw = 1'b0;
      if (s > 0) begin
         repeat (g) step();
         line_low_raw = 1'b1;
         repeat (s) step();
         line_low_raw = 1'b0;
      end
      repeat (30) step();
      chk(exp ? "R5 window trip" : "R4 blanked dropout", seen_bo, exp);
      chk("R3 clamp used", seen_cl, 1'b1);
      chk("R6 back to normal flag", bo_fault, 1'b0);
      chk("R6 back to normal clamp", clamp_en, 1'b0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // reset state
      repeat (3) @(negedge clk);
      chk("R1 reset flag", bo_fault, 1'b1);
      chk("R1 reset clamp", clamp_en, 1'b0);
      chk("R2 reset sink", sink_en, 1'b0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R2 sink before supply", sink_en, 1'b0);
      chk("R1 flag before supply", bo_fault, 1'b1);
      // supply ready with shutdown still held
      supply_ok = 1'b1;
      repeat (2) @(negedge clk);
      chk("R2 sink in shutdown after ready", sink_en, 1'b1);
      chk("R1 flag in shutdown", bo_fault, 1'b1);
      // leave shutdown with line low: must start in fault
      line_low_raw = 1'b1;
      shutdown_req = 1'b0;
      repeat (5) @(negedge clk);
      chk("R9 start in fault", bo_fault, 1'b1);
      chk("R7 sink on in fault", sink_en, 1'b1);
      chk("R7 clamp off in fault", clamp_en, 1'b0);
      // single clean sample must not release
      line_low_raw = 1'b0;
      @(negedge clk);
      line_low_raw = 1'b1;
      repeat (5) @(negedge clk);
      chk("R8 single sample keeps fault", bo_fault, 1'b1);
      line_low_raw = 1'b0;
      repeat (5) @(negedge clk);
      chk("R8 release", bo_fault, 1'b0);
      chk("R8 release sink", sink_en, 1'b0);

      // pattern table with tick on every cycle
      tick_ms = 1'b1;
      for (int i = 0; i < NV; i++) run_pat(P_LEN[i], P_GAP[i], P_SEC[i], P_EXP[i]);

      // clamp timing through the synchronizer, ticks stopped
      tick_ms = 1'b0;
      line_low_raw = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R3 clamp not yet", clamp_en, 1'b0);
      @(negedge clk);
      chk("R3 clamp on", clamp_en, 1'b1);
      repeat (20) @(negedge clk);
      chk("R4 no ticks no fault", bo_fault, 1'b0);
      chk("R4 clamp held", clamp_en, 1'b1);
      tick_ms = 1'b1;
      repeat (15) @(negedge clk);
      chk("R5 confirmed after ticks", bo_fault, 1'b1);
      chk("R7 clamp dropped", clamp_en, 1'b0);
      chk("R7 sink on", sink_en, 1'b1);
      line_low_raw = 1'b0;
      repeat (6) @(negedge clk);
      chk("R8 cleared", bo_fault, 1'b0);

      // hold-off in the middle of blanking, then a fresh sequence
      line_low_raw = 1'b1;
      repeat (4) @(negedge clk);
      chk("R10 in blanking", clamp_en, 1'b1);
      shutdown_req = 1'b1;
      line_low_raw = 1'b0;
      @(negedge clk);
      chk("R1 shutdown flag", bo_fault, 1'b1);
      chk("R1 shutdown clamp", clamp_en, 1'b0);
      shutdown_req = 1'b0;
      repeat (6) @(negedge clk);
      chk("R9 recovered", bo_fault, 1'b0);
      run_pat(5, 0, 0, 1'b0);
      chk("R10 fresh sequence no fault", seen_bo, 1'b0);

      // supply loss in normal operation
      supply_ok = 1'b0;
      @(negedge clk);
      chk("R1 supply loss flag", bo_fault, 1'b1);
      chk("R2 supply loss sink", sink_en, 1'b1);
      supply_ok = 1'b1;
      repeat (6) @(negedge clk);
      chk("R8 back after supply", bo_fault, 1'b0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule